// File: doc/BRIEF.md
# Descriptor-Chain Receive DMA Engine

This block is the receive side of a single DMA channel. A client offers bursts of bytes, each tagged with a length and an end-of-packet marker. The engine takes as many bytes as fit in the buffer of the current data descriptor, writes them one per cycle through a byte-wide memory write port, and returns the accepted count to the client. Bytes it does not take stay with the client, which may offer them again.

A descriptor closes when its buffer fills or when a burst carries end of packet. The engine then writes back the descriptor's end field, set to the actual fill point, and its received-end-of-packet flag. It also raises interrupt set bits for a separate register block. After that it either fetches the next descriptor in the chain, or, when the closed descriptor was the last in the list, marks the context disabled and refuses all further bursts until it is started again. The position reached is reported to a saved-position register after every accepted burst.

Top module: `dma_rx_chain`

## Requirements
- R1: The accepted count returned on `in_done`/`in_acc` equals the smaller of `in_len` and the remaining buffer space (descriptor end minus current position).
- R2: Accepted bytes are written one per `byte_take` cycle to consecutive addresses, starting at the current position, with `mem_data` equal to `byte_in`.
- R3: A descriptor closes (`wb_en` pulses together with `in_done`) when the position reaches the descriptor end or the burst carries end of packet. `wb_addr` is the descriptor address and `wb_end` is the final position.
- R4: `wb_in_eop` is 1 on a close caused by a burst carrying end of packet, and 0 otherwise.
- R5: On close, `intr_set` has bits 0 and 1 set when the descriptor's interrupt flag is set, and bit 3 set when the burst carried end of packet. In every other cycle `intr_set` is zero.
- R6: `intr_upd` pulses only when `intr_set` contains a bit that is not already set in `raw_intr`.
- R7: Closing a last-in-list descriptor pulses `ctx_dis`. After that, every burst is refused with an accepted count of 0, no memory write and no position report, until `start_i` is applied.
- R8: Closing any other descriptor fetches the descriptor at its next-pointer address, and the following burst starts at that descriptor's buffer start.
- R9: Every burst that is not refused pulses `pos_wr` together with `in_done`, with `pos_val` equal to the updated position. This includes bursts that accept 0 bytes.
- R10: After reset the engine writes nothing, requests no descriptor, and refuses bursts until `start_i` loads a first descriptor from `start_addr`.
- R11: A burst that does not close the descriptor leaves the descriptor current, and the next burst continues at the position where the previous one stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load first descriptor and leave the refusing state |
| start_addr | input | AW | Address of the first descriptor |
| dsc_req | output | 1 | Descriptor fetch request, held until acknowledged |
| dsc_addr | output | AW | Address of the descriptor being fetched |
| dsc_ack | input | 1 | Fetch response valid |
| dsc_next | input | AW | Fetched next-descriptor pointer |
| dsc_buf | input | AW | Fetched buffer start |
| dsc_end | input | AW | Fetched buffer end (exclusive) |
| dsc_eol | input | 1 | Fetched last-in-list flag |
| dsc_intr | input | 1 | Fetched interrupt-on-close flag |
| in_valid | input | 1 | Burst offered; held until in_done |
| in_len | input | LW | Offered burst length in bytes |
| in_eop | input | 1 | Burst ends a packet |
| in_done | output | 1 | Burst finished; in_acc valid |
| in_acc | output | LW | Bytes accepted from the burst |
| byte_take | output | 1 | Consume one byte from byte_in |
| byte_in | input | DW | Next client byte |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | AW | Buffer byte write address |
| mem_data | output | DW | Buffer byte write data |
| pos_wr | output | 1 | Saved-position register update strobe |
| pos_val | output | AW | Position after the burst |
| wb_en | output | 1 | Descriptor write-back strobe |
| wb_addr | output | AW | Address of the descriptor written back |
| wb_end | output | AW | Rewritten end field (actual fill point) |
| wb_in_eop | output | 1 | Received-end-of-packet flag written back |
| ctx_dis | output | 1 | Context disabled at end of list |
| raw_intr | input | 4 | Current raw interrupt register value |
| intr_set | output | 4 | Interrupt bits to OR into the raw register |
| intr_upd | output | 1 | Raw interrupt value changes; re-evaluate the line |

## Verification
The two close causes can occur in the same cycle: a burst carrying end of packet may also fill the buffer exactly to its end. This is provoked with an eight-byte packet offered to an eight-byte last-in-list descriptor. The close must produce one write-back with the end field at the buffer end, the received-end-of-packet flag set, interrupt bits 0, 1 and 3, and the context-disable pulse, all in the single done cycle. In the same case the interrupt change strobe is judged against a raw register that already holds every offered bit, so the strobe must stay low even though the bits are set again.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_FETCH = 2'd1,
      ST_MOVE  = 2'd2,
      ST_FIN   = 2'd3
   } rx_state_e;

   localparam int IRQ_W     = 4;
   localparam int IRQ_DONE0 = 0;
   localparam int IRQ_DONE1 = 1;
   localparam int IRQ_PKT   = 3;
endpackage

// File: rtl/dma_rx_span.sv
module dma_rx_span #(
   parameter int AW = 16,
   parameter int LW = 12
) (
   input  logic [AW-1:0] pos,
   input  logic [AW-1:0] lim,
   input  logic [LW-1:0] offer,
   output logic [LW-1:0] take
);
   logic [AW-1:0] space;
   logic [LW-1:0] room;

   assign space = lim - pos;

   generate
      if (AW > LW) begin : g_clip
         assign room = (|space[AW-1:LW]) ? {LW{1'b1}} : space[LW-1:0];
      end else if (AW == LW) begin : g_same
         assign room = space;
      end else begin : g_wide
         $error("dma_rx_span: LW must not exceed AW");
         assign room = {{(LW-AW){1'b0}}, space};
      end
   endgenerate

   assign take = (offer < room) ? offer : room;
endmodule

// File: rtl/dma_rx_irq.sv
module dma_rx_irq
   import dma_rx_pkg::*;
(
   input  logic             close,
   input  logic             want_irq,
   input  logic             pkt_end,
   input  logic [IRQ_W-1:0] raw,
   output logic [IRQ_W-1:0] set_bits,
   output logic             changed
);
   always_comb begin
      set_bits = '0;
      if (close) begin
         set_bits[IRQ_DONE0] = want_irq;
         set_bits[IRQ_DONE1] = want_irq;
         set_bits[IRQ_PKT]   = pkt_end;
      end
   end

   assign changed = |(set_bits & ~raw);
endmodule

// File: rtl/dma_rx_chain.sv
module dma_rx_chain
   import dma_rx_pkg::*;
#(
   parameter int AW = 16,
   parameter int LW = 12,
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [AW-1:0]    start_addr,
   output logic             dsc_req,
   output logic [AW-1:0]    dsc_addr,
   input  logic             dsc_ack,
   input  logic [AW-1:0]    dsc_next,
   input  logic [AW-1:0]    dsc_buf,
   input  logic [AW-1:0]    dsc_end,
   input  logic             dsc_eol,
   input  logic             dsc_intr,
   input  logic             in_valid,
   input  logic [LW-1:0]    in_len,
   input  logic             in_eop,
   output logic             in_done,
   output logic [LW-1:0]    in_acc,
   output logic             byte_take,
   input  logic [DW-1:0]    byte_in,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_data,
   output logic             pos_wr,
   output logic [AW-1:0]    pos_val,
   output logic             wb_en,
   output logic [AW-1:0]    wb_addr,
   output logic [AW-1:0]    wb_end,
   output logic             wb_in_eop,
   output logic             ctx_dis,
   input  logic [IRQ_W-1:0] raw_intr,
   output logic [IRQ_W-1:0] intr_set,
   output logic             intr_upd
);
   localparam logic [LW-1:0] LEN_ONE = LW'(1);
   localparam logic [AW-1:0] POS_ONE = AW'(1);

   generate
      if (DW < 1) begin : g_bad_dw
         $error("dma_rx_chain: DW must be at least 1");
      end
   endgenerate

   rx_state_e     state;
   logic          eol_q;
   logic          refuse_q;
   logic          eop_q;
   logic          deol_q;
   logic          dint_q;
   logic [AW-1:0] fetch_a;
   logic [AW-1:0] cur_a;
   logic [AW-1:0] nxt_a;
   logic [AW-1:0] end_q;
   logic [AW-1:0] pos_q;
   logic [LW-1:0] cnt_q;
   logic [LW-1:0] acc_q;
   logic [LW-1:0] span_acc;
   logic          closing;

   dma_rx_span #(.AW(AW), .LW(LW)) u_span (
      .pos   (pos_q),
      .lim   (end_q),
      .offer (in_len),
      .take  (span_acc)
   );

   assign closing = (state == ST_FIN) && !refuse_q
                    && ((pos_q == end_q) || eop_q);

   dma_rx_irq u_irq (
      .close    (closing),
      .want_irq (dint_q),
      .pkt_end  (eop_q),
      .raw      (raw_intr),
      .set_bits (intr_set),
      .changed  (intr_upd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_READY;
         eol_q    <= 1'b1;
         refuse_q <= 1'b0;
         eop_q    <= 1'b0;
         deol_q   <= 1'b0;
         dint_q   <= 1'b0;
         fetch_a  <= '0;
         cur_a    <= '0;
         nxt_a    <= '0;
         end_q    <= '0;
         pos_q    <= '0;
         cnt_q    <= '0;
         acc_q    <= '0;
      end else begin
         unique case (state)
            ST_READY: begin
               if (start_i) begin
                  fetch_a <= start_addr;
                  eol_q   <= 1'b0;
                  state   <= ST_FETCH;
               end else if (in_valid) begin
                  eop_q <= in_eop;
                  if (eol_q) begin
                     refuse_q <= 1'b1;
                     acc_q    <= '0;
                     state    <= ST_FIN;
                  end else begin
                     refuse_q <= 1'b0;
                     acc_q    <= span_acc;
                     cnt_q    <= span_acc;
                     state    <= (span_acc == '0) ? ST_FIN : ST_MOVE;
                  end
               end
            end
            ST_FETCH: begin
               if (dsc_ack) begin
                  cur_a  <= fetch_a;
                  nxt_a  <= dsc_next;
                  end_q  <= dsc_end;
                  pos_q  <= dsc_buf;
                  deol_q <= dsc_eol;
                  dint_q <= dsc_intr;
                  state  <= ST_READY;
               end
            end
            ST_MOVE: begin
               pos_q <= pos_q + POS_ONE;
               cnt_q <= cnt_q - LEN_ONE;
               if (cnt_q == LEN_ONE) state <= ST_FIN;
            end
            ST_FIN: begin
               if (closing) begin
                  if (deol_q) begin
                     eol_q <= 1'b1;
                     state <= ST_READY;
                  end else begin
                     fetch_a <= nxt_a;
                     state   <= ST_FETCH;
                  end
               end else begin
                  state <= ST_READY;
               end
            end
            default: state <= ST_READY;
         endcase
      end
   end

   assign dsc_req   = (state == ST_FETCH);
   assign dsc_addr  = fetch_a;
   assign byte_take = (state == ST_MOVE);
   assign mem_we    = (state == ST_MOVE);
   assign mem_addr  = pos_q;
   assign mem_data  = byte_in;
   assign in_done   = (state == ST_FIN);
   assign in_acc    = acc_q;
   assign pos_wr    = (state == ST_FIN) && !refuse_q;
   assign pos_val   = pos_q;
   assign wb_en     = closing;
   assign wb_addr   = cur_a;
   assign wb_end    = pos_q;
   assign wb_in_eop = eop_q;
   assign ctx_dis   = closing && deol_q;
endmodule

// File: rtl/dma_rx_chain_chk.sv
module dma_rx_chain_chk #(
   parameter int AW = 16,
   parameter int LW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          in_done,
   input logic [LW-1:0] in_acc,
   input logic [LW-1:0] in_len,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          pos_wr,
   input logic [AW-1:0] pos_val,
   input logic          wb_en,
   input logic [AW-1:0] wb_end,
   input logic          wb_in_eop,
   input logic          ctx_dis,
   input logic [3:0]    intr_set,
   input logic          intr_upd
);
   logic halted;

   always_ff @(posedge clk) begin
      if (!rst_n) halted <= 1'b1;
      else if (start_i) halted <= 1'b0;
      else if (ctx_dis) halted <= 1'b1;
   end

   p_acc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_done |-> in_acc <= in_len);

   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + AW'(1));

   p_wb_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (pos_wr && in_done && wb_end == pos_val));

   p_eop_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_in_eop) |-> intr_set[3]);

   p_irq_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_set != 4'd0) |-> wb_en);

   p_upd_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      intr_upd |-> (wb_en && intr_set != 4'd0));

   p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_we && !(in_done && in_acc != '0)));
endmodule

bind dma_rx_chain dma_rx_chain_chk #(.AW(AW), .LW(LW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .in_done   (in_done),
   .in_acc    (in_acc),
   .in_len    (in_len),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .pos_wr    (pos_wr),
   .pos_val   (pos_val),
   .wb_en     (wb_en),
   .wb_end    (wb_end),
   .wb_in_eop (wb_in_eop),
   .ctx_dis   (ctx_dis),
   .intr_set  (intr_set),
   .intr_upd  (intr_upd)
);

// File: tb/sim_dma_rx_chain.sv
`timescale 1ns/1ps
module sim_dma_rx_chain;
   localparam int AW = 16;
   localparam int LW = 12;
   localparam int DW = 8;

   // columns: len, eop, acc, poswr, pos, close, wb_eop, iset, upd, ctxdis, wbaddr
   localparam int NV = 5;
   localparam int VT [0:NV-1][0:10] = '{
      '{4, 0, 4, 1, 104, 0, 0, 0,  0, 0, 0},
      '{3, 1, 3, 1, 107, 1, 1, 11, 1, 0, 1},
      '{6, 0, 4, 1, 204, 1, 0, 0,  0, 0, 2},
      '{8, 1, 8, 1, 308, 1, 1, 11, 0, 1, 3},
      '{5, 0, 0, 0, 0,   0, 0, 0,  0, 0, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          dsc_req;
   logic [AW-1:0] dsc_addr;
   logic          dsc_ack = 1'b0;
   logic [AW-1:0] dsc_next = '0, dsc_buf = '0, dsc_end = '0;
   logic          dsc_eol = 1'b0, dsc_intr = 1'b0;
   logic          in_valid = 1'b0;
   logic [LW-1:0] in_len = '0;
   logic          in_eop = 1'b0;
   logic          in_done;
   logic [LW-1:0] in_acc;
   logic          byte_take;
   logic [DW-1:0] byte_in;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic          pos_wr;
   logic [AW-1:0] pos_val;
   logic          wb_en;
   logic [AW-1:0] wb_addr, wb_end;
   logic          wb_in_eop, ctx_dis;
   logic [3:0]    raw_intr = 4'd0;
   logic [3:0]    intr_set;
   logic          intr_upd;

   int n_chk = 0, n_fail = 0;
   int d_next [0:7], d_buf [0:7], d_end [0:7], d_eol [0:7], d_int [0:7];
   int bcount = 0, nwr = 0, first_a = 0, prev_a = 0, gaps = 0, dbad = 0;
   int fetched = 0;
   int r_acc, r_poswr, r_pos, r_wb, r_wbaddr, r_wbend, r_wbeop, r_iset, r_upd, r_ctx;

   assign byte_in = bcount[7:0];

   always #4 clk = ~clk;

   dma_rx_chain #(.AW(AW), .LW(LW), .DW(DW)) u0 (.*);

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // descriptor responder
   always @(negedge clk) begin
      if (dsc_req && !dsc_ack) begin
         dsc_ack  = 1'b1;
         dsc_next = AW'(d_next[dsc_addr[2:0]]);
         dsc_buf  = AW'(d_buf[dsc_addr[2:0]]);
         dsc_end  = AW'(d_end[dsc_addr[2:0]]);
         dsc_eol  = d_eol[dsc_addr[2:0]][0];
         dsc_intr = d_int[dsc_addr[2:0]][0];
         fetched  = int'(dsc_addr);
      end else begin
         dsc_ack = 1'b0;
      end
   end

   // memory write monitor
   always @(negedge clk) begin
      if (mem_we) begin
         if (nwr == 0) first_a = int'(mem_addr);
         else if (int'(mem_addr) != prev_a + 1) gaps++;
         if (!byte_take || mem_data != bcount[7:0]) dbad++;
         prev_a = int'(mem_addr);
         nwr++;
         bcount++;
      end
   end

   task automatic burst(input int len, input int eop);
      nwr = 0; gaps = 0; dbad = 0;
      @(negedge clk);
      in_valid = 1'b1;
      in_len   = LW'(len);
      in_eop   = eop[0];
      forever begin
         @(negedge clk);
         if (in_done) break;
      end
      r_acc = int'(in_acc); r_poswr = int'(pos_wr); r_pos = int'(pos_val);
      r_wb = int'(wb_en); r_wbaddr = int'(wb_addr); r_wbend = int'(wb_end);
      r_wbeop = int'(wb_in_eop); r_iset = int'(intr_set);
      r_upd = int'(intr_upd); r_ctx = int'(ctx_dis);
      raw_intr = raw_intr | intr_set;
      in_valid = 1'b0;
   endtask

   task automatic start_at(input int a);
      @(negedge clk);
      start_i = 1'b1;
      start_addr = AW'(a);
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #1600000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         d_next[i] = 0; d_buf[i] = 0; d_end[i] = 0; d_eol[i] = 1; d_int[i] = 0;
      end
      d_next[1] = 2; d_buf[1] = 100; d_end[1] = 110; d_eol[1] = 0; d_int[1] = 1;
      d_next[2] = 3; d_buf[2] = 200; d_end[2] = 204; d_eol[2] = 0; d_int[2] = 0;
      d_next[3] = 0; d_buf[3] = 300; d_end[3] = 308; d_eol[3] = 1; d_int[3] = 1;
      d_buf[4] = 400; d_end[4] = 400; d_eol[4] = 1; d_int[4] = 1;
      d_buf[5] = 500; d_end[5] = 520; d_eol[5] = 1; d_int[5] = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10 dsc_req after reset", int'(dsc_req), 0);
      check("R10 mem_we after reset", int'(mem_we), 0);
      check("R10 in_done after reset", int'(in_done), 0);
      burst(7, 0);
      check("R10 refused before start acc", r_acc, 0);
      check("R10 no pos report when refused", r_poswr, 0);
      check("R10 no writes when refused", nwr, 0);

      start_at(1);
      check("R10 first fetch from start_addr", fetched, 1);

      for (int v = 0; v < NV; v++) begin
         burst(VT[v][0], VT[v][1]);
         check("R1 accepted length", r_acc, VT[v][2]);
         check("R2 byte writes", nwr, VT[v][2]);
         check("R2 consecutive and data", gaps + dbad, 0);
         if (VT[v][2] > 0) check("R2 R11 first write address", first_a, VT[v][4] - VT[v][2]);
         check("R9 pos_wr", r_poswr, VT[v][3]);
         if (VT[v][3] != 0) check("R9 pos_val", r_pos, VT[v][4]);
         check("R3 close", r_wb, VT[v][5]);
         if (VT[v][5] != 0) begin
            check("R3 wb_addr", r_wbaddr, VT[v][10]);
            check("R3 wb_end", r_wbend, VT[v][4]);
            check("R4 wb_in_eop", r_wbeop, VT[v][6]);
         end
         check("R5 intr_set", r_iset, VT[v][7]);
         check("R6 intr_upd", r_upd, VT[v][8]);
         check("R7 ctx_dis", r_ctx, VT[v][9]);
         if (v == 1 || v == 2) begin
            repeat (4) @(negedge clk);
            check("R8 next descriptor fetched", fetched, VT[v][10] + 1);
         end
      end

      // zero-length descriptor with interrupt and end of list
      raw_intr = 4'd0;
      start_at(4);
      burst(3, 0);
      check("R1 zero space accepts 0", r_acc, 0);
      check("R9 pos_wr on 0-byte burst", r_poswr, 1);
      check("R3 full close on empty buffer", r_wb, 1);
      check("R3 wb_end empty buffer", r_wbend, 400);
      check("R4 no eop flag", r_wbeop, 0);
      check("R5 intr bits 0,1", r_iset, 3);
      check("R6 new bits flag update", r_upd, 1);
      check("R7 ctx_dis on empty eol", r_ctx, 1);
      burst(2, 1);
      check("R7 refused after end of list", r_acc, 0);
      check("R7 no write-back when refused", r_wb, 0);
      check("R7 no writes when refused", nwr, 0);

      // zero-length burst carrying end of packet closes early
      start_at(5);
      burst(0, 1);
      check("R3 early close on eop", r_wb, 1);
      check("R3 wb_end at buffer start", r_wbend, 500);
      check("R4 eop flag written", r_wbeop, 1);
      check("R5 eop bit only", r_iset, 8);
      check("R6 update for new bit 3", r_upd, 1);
      check("R7 ctx_dis", r_ctx, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule